// File: doc/BRIEF.md
# Segmented RTD Ratio-Code to Temperature Converter

This block turns a 16-bit left-justified resistance-ratio code from a platinum-sensor converter into a signed temperature in hundredths of a degree Celsius. It holds a reset-time table of linear segments. Each row carries a breakpoint code, the temperature at that breakpoint in micro-degrees, an offset coefficient and a slope coefficient. A code is taken over a valid/ready handshake. The block walks the breakpoints one row per clock to find the segment that holds the code. It then forms offset plus slope times code at 48 bits and scales the result down to centi-degrees. The result leaves as a one-cycle valid pulse together with an error flag.

A code below the first breakpoint or above the last breakpoint is rejected rather than clamped. The block raises the error flag and reports a temperature of zero. While a conversion is still searching, the input is held off by a low ready.

Top module: `rtd_lin_conv`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: The default table has ROWS rows (default 86), all columns signed 32-bit. For row i, the breakpoint is c(i) = 3678 + floor((85780·i − 154·i²)/100), which runs from 0x0E5E up to 0xFFB8. The breakpoint temperature is t(i) = −200000000 + 10000000·i micro-degrees. The slope is a1(i) = floor(10000000/(c(i+1) − c(i))), and the last row reuses the span of the row before it. The offset is a0(i) = t(i) − a1(i)·c(i).
- R3: For an in-range code, the segment used is k = j − 1, where j is the lowest row index whose breakpoint is strictly greater than the code. A code equal to a breakpoint c(i) therefore uses row i.
- R4: The result is (a0(k) + a1(k)·code) divided by 10000, with the quotient truncated toward zero. For a negative value this means rounding up. out_err is 0 with that result.
- R5: A code equal to the last breakpoint uses the last row and yields t(ROWS−1)/10000 (65000 by default).
- R6: A code equal to the first breakpoint uses row 0 and yields t(0)/10000 (−20000 by default).
- R7: A code below c(0) or above c(ROWS−1) produces out_valid with out_err = 1 and out_temp = 0.
- R8: After a code is accepted, in_ready stays 0 until that code's segment search ends. A valid input offered during that time is not taken: it produces no output and does not change the result of the accepted code.
- R9: Each accepted code yields exactly one out_valid pulse, at most ROWS+4 clock edges after acceptance.
- R10: For every in-range code, out_temp lies between t(0)/10000 and t(ROWS−1)/10000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A code is offered |
| in_code | input | 16 | Left-justified ratio code |
| in_ready | output | 1 | The block can take a code this cycle |
| out_valid | output | 1 | One-cycle result strobe |
| out_err | output | 1 | Code was outside the table span |
| out_temp | output | 32 | Signed temperature in 0.01 °C, zero on error |

## Verification
The embedded properties check several things on every cycle. The selected breakpoint never lies above the code. A code equal to the last breakpoint picks the last row. Ready drops after each acceptance. Results are single-cycle strobes traced back to a selection or a rejection two cycles earlier. Every in-range result stays inside the table's temperature span. The bench is needed for the rest: the arithmetic values themselves, truncation toward zero on negative temperatures, exact breakpoint and one-off-breakpoint codes, the latency bound, and proof that an input offered while busy leaves no trace.

// File: rtl/rtd_lin_pkg.sv
`timescale 1ns/1ps
package rtd_lin_pkg;

  localparam int COL_W = 32;

  // shape of the default segment table
  localparam int BP_BASE = 3678;
  localparam int BP_LIN  = 85780;
  localparam int BP_QUAD = 154;
  localparam int BP_DIV  = 100;
  localparam int T_BASE  = -200000000;
  localparam int T_STEP  = 10000000;

  typedef struct packed {
    logic signed [COL_W-1:0] bp;
    logic signed [COL_W-1:0] tmp;
    logic signed [COL_W-1:0] a0;
    logic signed [COL_W-1:0] a1;
  } seg_row_t;

  typedef enum logic [1:0] {
    SRCH_IDLE = 2'd0,
    SRCH_SCAN = 2'd1,
    SRCH_PICK = 2'd2,
    SRCH_REJ  = 2'd3
  } srch_state_e;

  function automatic int bp_at(int i);
    return BP_BASE + (BP_LIN * i - BP_QUAD * i * i) / BP_DIV;
  endfunction

  function automatic seg_row_t row_at(int i, int rows);
    seg_row_t r;
    int span;
    int slope;
    if (i < rows - 1) span = bp_at(i + 1) - bp_at(i);
    else              span = bp_at(i) - bp_at(i - 1);
    slope = T_STEP / span;
    r.bp  = bp_at(i);
    r.tmp = T_BASE + T_STEP * i;
    r.a1  = slope;
    r.a0  = r.tmp - slope * r.bp;
    return r;
  endfunction

endpackage

// File: rtl/rtd_lin_rst_sync.sv
`timescale 1ns/1ps
module rtd_lin_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/rtd_lin_table.sv
`timescale 1ns/1ps
module rtd_lin_table
  import rtd_lin_pkg::*;
#(
  parameter int ROWS = 86,
  parameter int IW   = $clog2(ROWS)
) (
  input  logic [IW-1:0]           rd_idx,
  output logic signed [COL_W-1:0] rd_bp,
  output logic signed [COL_W-1:0] rd_a0,
  output logic signed [COL_W-1:0] rd_a1,
  output logic signed [COL_W-1:0] first_bp,
  output logic signed [COL_W-1:0] last_bp
);

  logic signed [COL_W-1:0] bp_rom [ROWS];
  logic signed [COL_W-1:0] a0_rom [ROWS];
  logic signed [COL_W-1:0] a1_rom [ROWS];

  for (genvar g = 0; g < ROWS; g++) begin : g_rom
    localparam seg_row_t ROW = row_at(g, ROWS);
    assign bp_rom[g] = ROW.bp;
    assign a0_rom[g] = ROW.a0;
    assign a1_rom[g] = ROW.a1;
  end

  logic idx_ok;
  assign idx_ok = (int'(rd_idx) < ROWS);

  always_comb begin
    rd_bp = '0;
    rd_a0 = '0;
    rd_a1 = '0;
    if (idx_ok) begin
      rd_bp = bp_rom[rd_idx];
      rd_a0 = a0_rom[rd_idx];
      rd_a1 = a1_rom[rd_idx];
    end
  end

  assign first_bp = bp_rom[0];
  assign last_bp  = bp_rom[ROWS-1];

endmodule

// File: rtl/rtd_lin_search.sv
`timescale 1ns/1ps
module rtd_lin_search
  import rtd_lin_pkg::*;
#(
  parameter int ROWS   = 86,
  parameter int CODE_W = 16,
  parameter int IW     = $clog2(ROWS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [CODE_W-1:0]       in_code,
  output logic                    in_ready,
  output logic [IW-1:0]           rd_idx,
  input  logic signed [COL_W-1:0] rd_bp,
  input  logic signed [COL_W-1:0] first_bp,
  input  logic signed [COL_W-1:0] last_bp,
  output logic                    seg_vld,
  output logic                    rng_err,
  output logic [CODE_W-1:0]       code_out
);

  localparam int PAD_W = COL_W - CODE_W;
  localparam logic [IW-1:0] LAST_IDX = IW'(ROWS - 1);

  srch_state_e             st_q, st_d;
  logic [IW-1:0]           idx_q, idx_d;
  logic [CODE_W-1:0]       code_q;
  logic                    code_en;
  logic signed [COL_W-1:0] in_ext, code_ext;
  logic                    below, above, code_lt_bp, accept;

  assign in_ext     = $signed({{PAD_W{1'b0}}, in_code});
  assign code_ext   = $signed({{PAD_W{1'b0}}, code_q});
  assign below      = (in_ext < first_bp);
  assign above      = (in_ext > last_bp);
  assign code_lt_bp = (code_ext < rd_bp);
  assign in_ready   = (st_q == SRCH_IDLE);
  assign accept     = in_valid && in_ready;

  // next-state process
  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    code_en = 1'b0;
    unique case (st_q)
      SRCH_IDLE: begin
        if (in_valid) begin
          code_en = 1'b1;
          if (below || above) begin
            st_d = SRCH_REJ;
          end else begin
            st_d  = SRCH_SCAN;
            idx_d = IW'(1);
          end
        end
      end
      SRCH_SCAN: begin
        if (code_lt_bp) begin
          st_d  = SRCH_PICK;
          idx_d = idx_q - IW'(1);
        end else if (idx_q == LAST_IDX) begin
          st_d = SRCH_PICK;
        end else begin
          idx_d = idx_q + IW'(1);
        end
      end
      SRCH_PICK: st_d = SRCH_IDLE;
      SRCH_REJ:  st_d = SRCH_IDLE;
      default:   st_d = SRCH_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SRCH_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= in_code;
  end

  assign rd_idx   = idx_q;
  assign seg_vld  = (st_q == SRCH_PICK);
  assign rng_err  = (st_q == SRCH_REJ);
  assign code_out = code_q;

  // R3
  sel_bp_not_above_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_vld |-> !(code_ext < rd_bp));

  // R5
  last_bp_uses_last_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_vld && (code_ext == last_bp)) |-> (rd_idx == LAST_IDX));

  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R7
  reject_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rng_err |-> $past(accept));

endmodule

// File: rtl/rtd_lin_datapath.sv
`timescale 1ns/1ps
module rtd_lin_datapath
  import rtd_lin_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int ACC_W  = 48,
  parameter int TEMP_W = 32,
  parameter int SCALE  = 10000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seg_vld,
  input  logic                    rng_err,
  input  logic signed [COL_W-1:0] row_a0,
  input  logic signed [COL_W-1:0] row_a1,
  input  logic [CODE_W-1:0]       code,
  output logic                    out_valid,
  output logic                    out_err,
  output logic [TEMP_W-1:0]       out_temp
);

  localparam logic signed [ACC_W-1:0] SCALE_X = ACC_W'(SCALE);

  logic signed [ACC_W-1:0] a0_x, a1_x, code_x, mac_d, acc_q;
  logic                    s1_vld_q, s1_err_q;
  logic                    s1_vld_d, s1_err_d;
  logic [TEMP_W-1:0]       temp_d, temp_q;
  logic                    oerr_q, ovld_q;

  assign a0_x   = ACC_W'(row_a0);
  assign a1_x   = ACC_W'(row_a1);
  assign code_x = $signed(ACC_W'(code));

  // stage 1: multiply-add at full width
  always_comb begin
    mac_d    = a0_x + a1_x * code_x;
    s1_vld_d = seg_vld || rng_err;
    s1_err_d = rng_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld_q <= 1'b0;
      s1_err_q <= 1'b0;
    end else begin
      s1_vld_q <= s1_vld_d;
      s1_err_q <= s1_err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       acc_q <= '0;
    else if (seg_vld) acc_q <= mac_d;
  end

  // stage 2: scale micro-degrees to centi-degrees, truncating toward zero
  always_comb begin
    if (s1_err_q) temp_d = '0;
    else          temp_d = TEMP_W'(acc_q / SCALE_X);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovld_q <= 1'b0;
      oerr_q <= 1'b0;
      temp_q <= '0;
    end else begin
      ovld_q <= s1_vld_q;
      if (s1_vld_q) begin
        oerr_q <= s1_err_q;
        temp_q <= temp_d;
      end
    end
  end

  assign out_valid = ovld_q;
  assign out_err   = oerr_q;
  assign out_temp  = temp_q;

  // R7
  err_traces_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> $past(rng_err, 2));

  // R4
  result_traces_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> $past(seg_vld, 2));

  // R9
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

endmodule

// File: rtl/rtd_lin_conv.sv
`timescale 1ns/1ps
module rtd_lin_conv
  import rtd_lin_pkg::*;
#(
  parameter int ROWS   = 86,
  parameter int CODE_W = 16,
  parameter int ACC_W  = 48,
  parameter int TEMP_W = 32,
  parameter int SCALE  = 10000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_err,
  output logic [TEMP_W-1:0] out_temp
);

  localparam int IW = $clog2(ROWS);
  localparam seg_row_t ROW_FIRST = row_at(0, ROWS);
  localparam seg_row_t ROW_LAST  = row_at(ROWS - 1, ROWS);
  localparam int TEMP_LO = ROW_FIRST.tmp / SCALE;
  localparam int TEMP_HI = ROW_LAST.tmp / SCALE;

  logic                    rst_n_s;
  logic [IW-1:0]           rd_idx;
  logic signed [COL_W-1:0] rd_bp, rd_a0, rd_a1, first_bp, last_bp;
  logic                    seg_vld, rng_err;
  logic [CODE_W-1:0]       code_q;

  rtd_lin_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rtd_lin_table #(.ROWS(ROWS), .IW(IW)) u_table (
    .rd_idx   (rd_idx),
    .rd_bp    (rd_bp),
    .rd_a0    (rd_a0),
    .rd_a1    (rd_a1),
    .first_bp (first_bp),
    .last_bp  (last_bp)
  );

  rtd_lin_search #(.ROWS(ROWS), .CODE_W(CODE_W), .IW(IW)) u_search (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_valid (in_valid),
    .in_code  (in_code),
    .in_ready (in_ready),
    .rd_idx   (rd_idx),
    .rd_bp    (rd_bp),
    .first_bp (first_bp),
    .last_bp  (last_bp),
    .seg_vld  (seg_vld),
    .rng_err  (rng_err),
    .code_out (code_q)
  );

  rtd_lin_datapath #(.CODE_W(CODE_W), .ACC_W(ACC_W), .TEMP_W(TEMP_W), .SCALE(SCALE)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .seg_vld   (seg_vld),
    .rng_err   (rng_err),
    .row_a0    (rd_a0),
    .row_a1    (rd_a1),
    .code      (code_q),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_temp  (out_temp)
  );

  // R10
  temp_in_span_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_err) |->
      (($signed(out_temp) >= TEMP_LO) && ($signed(out_temp) <= TEMP_HI)));

endmodule

// File: tb/rtd_lin_conv_tb.sv
`timescale 1ns/1ps
module rtd_lin_conv_tb;

  localparam int ROWS = 86;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_code;
  logic        in_ready;
  logic        out_valid;
  logic        out_err;
  logic [31:0] out_temp;

  int vectors = 0;
  int miscompares = 0;

  always #2 clk = ~clk;

  rtd_lin_conv u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_err   (out_err),
    .out_temp  (out_temp)
  );

  // expected-value model built from R2..R7
  function automatic int m_bp(int i);
    return 3678 + (85780 * i - 154 * i * i) / 100;
  endfunction

  function automatic int m_t(int i);
    return -200000000 + 10000000 * i;
  endfunction

  function automatic int m_a1(int i);
    int span;
    if (i < ROWS - 1) span = m_bp(i + 1) - m_bp(i);
    else              span = m_bp(i) - m_bp(i - 1);
    return 10000000 / span;
  endfunction

  function automatic int m_a0(int i);
    return m_t(i) - m_a1(i) * m_bp(i);
  endfunction

  function automatic void m_conv(input int code, output bit err, output int temp);
    int k;
    longint acc;
    if (code < m_bp(0) || code > m_bp(ROWS - 1)) begin
      err = 1'b1;
      temp = 0;
    end else begin
      k = ROWS - 1;
      for (int i = 1; i < ROWS; i++) begin
        if (code < m_bp(i)) begin
          k = i - 1;
          break;
        end
      end
      acc = longint'(m_a0(k)) + longint'(m_a1(k)) * longint'(code);
      temp = int'(acc / 64'sd10000);
      err = 1'b0;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // one conversion, with a busy-time poke (R8) and latency/strobe checks (R9)
  task automatic convert(input logic [15:0] code, input string tag);
    bit e_err;
    int e_t;
    int n;
    bit seen;
    m_conv(int'(code), e_err, e_t);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = code;
    while (!in_ready) @(negedge clk);
    n = 0;
    seen = 1'b0;
    while (!seen && n <= ROWS + 4) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        in_code  = ~code;
        in_valid = 1'b1;
        chk(in_ready == 1'b0, "R8", "ready while busy", in_ready, 0);
      end else if (n == 2) begin
        in_valid = 1'b0;
      end
      if (out_valid) seen = 1'b1;
    end
    if (n == 1) begin
      in_valid = 1'b0;
    end
    chk(seen, "R9", "result strobe within bound", n, ROWS + 4);
    if (seen) begin
      chk(out_err == e_err, tag, "error flag", out_err, e_err);
      chk($signed(out_temp) == e_t, tag, "temperature", $signed(out_temp), e_t);
      if (!e_err) begin
        // R10
        chk(($signed(out_temp) >= -20000) && ($signed(out_temp) <= 65000),
            "R10", "temperature span", $signed(out_temp), 0);
      end
    end
    // R8, R9: nothing more comes out for this code or for the poked one
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(!out_valid, "R8", "no extra strobe", out_valid, 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin : main
    int unsigned seed;
    logic [15:0] rc;
    in_valid = 1'b0;
    in_code  = '0;
    rst_n    = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "valid after reset", out_valid, 0);

    // R7: below and above the span
    convert(16'h0000, "R7");
    convert(16'(m_bp(0) - 1), "R7");
    convert(16'(m_bp(ROWS - 1) + 1), "R7");
    convert(16'hFFFF, "R7");
    // R6, R5: ends of the span
    convert(16'(m_bp(0)), "R6");
    convert(16'(m_bp(ROWS - 1)), "R5");
    convert(16'(m_bp(ROWS - 1) - 1), "R5");
    convert(16'(m_bp(0) + 1), "R4");
    // R2, R3: exact breakpoints and one below them
    for (int i = 1; i < ROWS - 1; i += 6) begin
      convert(16'(m_bp(i)), "R3");
      convert(16'(m_bp(i) - 1), "R3");
    end
    // R2: a breakpoint's exact temperature from the table rule
    convert(16'(m_bp(20)), "R2");

    // R4: random codes, in range and across the whole code space
    seed = $urandom(32'h1F2E3D4C);
    for (int r = 0; r < 300; r++) begin
      if (r % 2 == 0) rc = 16'(m_bp(0) + int'($urandom % 32'(m_bp(ROWS - 1) - m_bp(0) + 1)));
      else            rc = 16'($urandom);
      convert(rc, "R4");
    end

    report();
    $finish;
  end

endmodule